// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and the execution datapath of a multithreaded core. It keeps one buffered instruction per resident warp and a scoreboard of destination registers still in flight for each warp. Each cycle it looks at every buffered instruction and picks at most one whose source and destination registers are all free. The chosen instruction goes to an issue port, which presents it to the lanes of the warp one lane group at a time.

Fetch writes at most one instruction per cycle into a free warp slot. Writeback returns a warp number and a register number, and that clears the matching scoreboard bit. An instruction waiting on a long-latency result stays in its slot. Other warps keep issuing around it, so switching between warps costs no cycles. When several warps are ready, the one whose instruction has waited longest wins. A tie in age goes to the first ready warp after the one that issued last.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, every slot is empty (`slot_busy` all zero), `issue_valid` is 0 and `issue_lane_en` is all zero. The round-robin pointer then treats warp NUM_WARPS-1 as the last issued warp.
- R2: When `fill_valid` is high and the slot of `fill_warp` is empty, that slot holds the instruction and its register fields from the next cycle on. A fill aimed at an occupied slot is ignored and the older content is kept. This holds even when that slot is being issued in the same cycle.
- R3: A buffered instruction is eligible only when neither source register is pending for its warp and, if `fill_dst_en` was set, its destination is not pending either. A writeback takes effect in the cycle after the one that carries it.
- R4: Issuing an instruction with its destination enable set marks that register pending for that warp. A writeback pulse clears the bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R5: A selection is made only when the issue port is idle or in its last beat. `issue_valid` then stays high for BEATS cycles, with `issue_beat` counting 0 to BEATS-1. Warp, instruction and destination are held stable through all beats. A new issue may begin in the cycle right after the last beat.
- R6: While `issue_valid` is high, `issue_lane_en` enables exactly the lanes from beat*(LANES/BEATS) to (beat+1)*(LANES/BEATS)-1. It is zero when the port is idle.
- R7: Among eligible warps, the one with the greatest age is chosen. Age is 0 in the cycle after the fill, rises by one each cycle and saturates at 2^AGE_W-1.
- R8: When eligible warps tie in age, the search order starts at the warp after the last issued warp and wraps modulo NUM_WARPS. The first of the tied warps in that order is chosen.
- R9: A warp whose instruction is stalled on the scoreboard does not keep any other eligible warp from issuing.
- R10: A slot is freed on the clock edge that issues its instruction, and it can accept a new fill in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fetch presents an instruction |
| fill_warp | input | $clog2(NUM_WARPS) | Target warp slot |
| fill_inst | input | INST_W | Opaque instruction payload |
| fill_src_a | input | $clog2(NUM_REGS) | First source register |
| fill_src_b | input | $clog2(NUM_REGS) | Second source register |
| fill_dst | input | $clog2(NUM_REGS) | Destination register |
| fill_dst_en | input | 1 | Instruction writes its destination |
| wb_valid | input | 1 | Writeback pulse |
| wb_warp | input | $clog2(NUM_WARPS) | Warp of the returning result |
| wb_reg | input | $clog2(NUM_REGS) | Register whose pending bit clears |
| slot_busy | output | NUM_WARPS | Occupancy of each warp slot |
| issue_valid | output | 1 | Issue port is presenting an instruction |
| issue_warp | output | $clog2(NUM_WARPS) | Warp being issued |
| issue_inst | output | INST_W | Instruction being issued |
| issue_dst | output | $clog2(NUM_REGS) | Destination of the issued instruction |
| issue_dst_en | output | 1 | Issued instruction writes its destination |
| issue_beat | output | $clog2(BEATS) | Current lane-group beat |
| issue_lane_en | output | LANES | Lanes enabled in this beat |

## Verification
The bench aims at age ties, which come up often once ages saturate in a small configuration. A design that broke ties from warp 0 or from the wrong pointer would issue warps in the wrong order. It also goes after a writeback that arrives in the same cycle as an issue setting the same bit. Getting that precedence wrong would let a dependent instruction issue too early. A fill that lands on the slot being issued in that cycle is exercised too, since a design that accepted it would lose or duplicate an instruction. A long stall on one warp while others run is included; if the stalled warp blocked issue, no other warp would appear on the port.

// File: rtl/wis_pkg.sv
package wis_pkg;
   typedef enum logic [0:0] {
      PORT_IDLE = 1'b0,
      PORT_BUSY = 1'b1
   } port_state_e;
endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
   parameter int NUM_WARPS = 24,
   parameter int NUM_REGS  = 16,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [WID_W-1:0]     set_warp,
   input  logic [REG_W-1:0]     set_reg,
   input  logic                 clr_en,
   input  logic [WID_W-1:0]     clr_warp,
   input  logic [REG_W-1:0]     clr_reg,
   output logic [NUM_REGS-1:0]  pend [NUM_WARPS]
);
   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [NUM_REGS-1:0] nxt;
      always_comb begin
         nxt = pend[w];
         if (clr_en && clr_warp == WID_W'(w)) nxt[clr_reg] = 1'b0;
         if (set_en && set_warp == WID_W'(w)) nxt[set_reg] = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[w] <= '0;
         else        pend[w] <= nxt;
      end
   end
endmodule

// File: rtl/wis_slot_buf.sv
module wis_slot_buf #(
   parameter int NUM_WARPS = 24,
   parameter int NUM_REGS  = 16,
   parameter int INST_W    = 32,
   parameter int AGE_W     = 4,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam logic [AGE_W-1:0] AGE_MAX = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   input  logic [WID_W-1:0]  fill_warp,
   input  logic [INST_W-1:0] fill_inst,
   input  logic [REG_W-1:0]  fill_src_a,
   input  logic [REG_W-1:0]  fill_src_b,
   input  logic [REG_W-1:0]  fill_dst,
   input  logic              fill_dst_en,
   input  logic              take_en,
   input  logic [WID_W-1:0]  take_warp,
   output logic              v      [NUM_WARPS],
   output logic [INST_W-1:0] inst   [NUM_WARPS],
   output logic [REG_W-1:0]  src_a  [NUM_WARPS],
   output logic [REG_W-1:0]  src_b  [NUM_WARPS],
   output logic [REG_W-1:0]  dst    [NUM_WARPS],
   output logic              dst_en [NUM_WARPS],
   output logic [AGE_W-1:0]  age    [NUM_WARPS]
);
   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      logic hit_take, hit_fill;
      assign hit_take = take_en && take_warp == WID_W'(w);
      assign hit_fill = fill_valid && fill_warp == WID_W'(w) && !v[w];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v[w]      <= 1'b0;
            age[w]    <= '0;
            inst[w]   <= '0;
            src_a[w]  <= '0;
            src_b[w]  <= '0;
            dst[w]    <= '0;
            dst_en[w] <= 1'b0;
         end else if (hit_take) begin
            v[w]      <= 1'b0;
         end else if (hit_fill) begin
            v[w]      <= 1'b1;
            age[w]    <= '0;
            inst[w]   <= fill_inst;
            src_a[w]  <= fill_src_a;
            src_b[w]  <= fill_src_b;
            dst[w]    <= fill_dst;
            dst_en[w] <= fill_dst_en;
         end else if (v[w] && age[w] != AGE_MAX) begin
            age[w]    <= age[w] + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wis_pick.sv
module wis_pick #(
   parameter int NUM_WARPS = 24,
   parameter int AGE_W     = 4,
   localparam int WID_W    = $clog2(NUM_WARPS)
) (
   input  logic             elig [NUM_WARPS],
   input  logic [AGE_W-1:0] age  [NUM_WARPS],
   input  logic [WID_W-1:0] last,
   output logic             any,
   output logic [WID_W-1:0] win
);
   logic [AGE_W-1:0] best;
   always_comb begin
      any  = 1'b0;
      win  = '0;
      best = '0;
      for (int k = 0; k < NUM_WARPS; k++) begin
         int idx;
         idx = int'(last) + 1 + k;
         if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
         if (elig[idx] && (!any || age[idx] > best)) begin
            any  = 1'b1;
            best = age[idx];
            win  = WID_W'(idx);
         end
      end
   end
endmodule

// File: rtl/wis_issue_port.sv
module wis_issue_port
   import wis_pkg::*;
#(
   parameter int NUM_WARPS = 24,
   parameter int NUM_REGS  = 16,
   parameter int INST_W    = 32,
   parameter int LANES     = 32,
   parameter int BEATS     = 4,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int BEAT_W   = $clog2(BEATS),
   localparam int GROUP    = LANES / BEATS,
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WID_W-1:0]  ld_warp,
   input  logic [INST_W-1:0] ld_inst,
   input  logic [REG_W-1:0]  ld_dst,
   input  logic              ld_dst_en,
   output logic              can_load,
   output logic              o_valid,
   output logic [WID_W-1:0]  o_warp,
   output logic [INST_W-1:0] o_inst,
   output logic [REG_W-1:0]  o_dst,
   output logic              o_dst_en,
   output logic [BEAT_W-1:0] o_beat,
   output logic [LANES-1:0]  o_lane_en
);
   port_state_e st;
   assign o_valid  = (st == PORT_BUSY);
   assign can_load = (st == PORT_IDLE) || (o_beat == LAST_BEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PORT_IDLE;
         o_beat   <= '0;
         o_warp   <= WID_W'(NUM_WARPS - 1);
         o_inst   <= '0;
         o_dst    <= '0;
         o_dst_en <= 1'b0;
      end else if (load) begin
         st       <= PORT_BUSY;
         o_beat   <= '0;
         o_warp   <= ld_warp;
         o_inst   <= ld_inst;
         o_dst    <= ld_dst;
         o_dst_en <= ld_dst_en;
      end else if (st == PORT_BUSY) begin
         if (o_beat == LAST_BEAT) begin
            st     <= PORT_IDLE;
            o_beat <= '0;
         end else begin
            o_beat <= o_beat + 1'b1;
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign o_lane_en[l] = o_valid && (o_beat == BEAT_W'(l / GROUP));
   end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int NUM_WARPS = 24,
   parameter int NUM_REGS  = 16,
   parameter int INST_W    = 32,
   parameter int AGE_W     = 4,
   parameter int LANES     = 32,
   parameter int BEATS     = 4,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int BEAT_W   = $clog2(BEATS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_valid,
   input  logic [WID_W-1:0]     fill_warp,
   input  logic [INST_W-1:0]    fill_inst,
   input  logic [REG_W-1:0]     fill_src_a,
   input  logic [REG_W-1:0]     fill_src_b,
   input  logic [REG_W-1:0]     fill_dst,
   input  logic                 fill_dst_en,
   input  logic                 wb_valid,
   input  logic [WID_W-1:0]     wb_warp,
   input  logic [REG_W-1:0]     wb_reg,
   output logic [NUM_WARPS-1:0] slot_busy,
   output logic                 issue_valid,
   output logic [WID_W-1:0]     issue_warp,
   output logic [INST_W-1:0]    issue_inst,
   output logic [REG_W-1:0]     issue_dst,
   output logic                 issue_dst_en,
   output logic [BEAT_W-1:0]    issue_beat,
   output logic [LANES-1:0]     issue_lane_en
);
   if (NUM_WARPS < 2 || NUM_REGS < 2 || BEATS < 2 || AGE_W < 1)
      begin : g_bad_size
         $error("warp_issue_sched: sizes below minimum");
      end
   if (LANES % BEATS != 0) begin : g_bad_lanes
      $error("warp_issue_sched: LANES must be a multiple of BEATS");
   end

   logic              slot_v   [NUM_WARPS];
   logic [INST_W-1:0] slot_inst[NUM_WARPS];
   logic [REG_W-1:0]  slot_sa  [NUM_WARPS];
   logic [REG_W-1:0]  slot_sb  [NUM_WARPS];
   logic [REG_W-1:0]  slot_dst [NUM_WARPS];
   logic              slot_de  [NUM_WARPS];
   logic [AGE_W-1:0]  slot_age [NUM_WARPS];
   logic [NUM_REGS-1:0] pend   [NUM_WARPS];
   logic              elig     [NUM_WARPS];
   logic              any_elig, can_load, sel_fire;
   logic [WID_W-1:0]  sel_warp;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
      assign elig[w] = slot_v[w] && !pend[w][slot_sa[w]] && !pend[w][slot_sb[w]]
                       && !(slot_de[w] && pend[w][slot_dst[w]]);
      assign slot_busy[w] = slot_v[w];
   end

   assign sel_fire = can_load && any_elig;

   wis_slot_buf #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .INST_W(INST_W),
                  .AGE_W(AGE_W)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_inst(fill_inst),
      .fill_src_a(fill_src_a), .fill_src_b(fill_src_b), .fill_dst(fill_dst),
      .fill_dst_en(fill_dst_en), .take_en(sel_fire), .take_warp(sel_warp),
      .v(slot_v), .inst(slot_inst), .src_a(slot_sa), .src_b(slot_sb),
      .dst(slot_dst), .dst_en(slot_de), .age(slot_age));

   wis_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .set_en(sel_fire && slot_de[sel_warp]), .set_warp(sel_warp),
      .set_reg(slot_dst[sel_warp]),
      .clr_en(wb_valid), .clr_warp(wb_warp), .clr_reg(wb_reg), .pend(pend));

   wis_pick #(.NUM_WARPS(NUM_WARPS), .AGE_W(AGE_W)) u_pick (
      .elig(elig), .age(slot_age), .last(issue_warp),
      .any(any_elig), .win(sel_warp));

   wis_issue_port #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .INST_W(INST_W),
                    .LANES(LANES), .BEATS(BEATS)) u_port (
      .clk(clk), .rst_n(rst_n), .load(sel_fire), .ld_warp(sel_warp),
      .ld_inst(slot_inst[sel_warp]), .ld_dst(slot_dst[sel_warp]),
      .ld_dst_en(slot_de[sel_warp]), .can_load(can_load),
      .o_valid(issue_valid), .o_warp(issue_warp), .o_inst(issue_inst),
      .o_dst(issue_dst), .o_dst_en(issue_dst_en), .o_beat(issue_beat),
      .o_lane_en(issue_lane_en));
endmodule

// File: rtl/wis_chk.sv
module wis_chk #(
   parameter int NUM_WARPS = 24,
   parameter int NUM_REGS  = 16,
   parameter int INST_W    = 32,
   parameter int LANES     = 32,
   parameter int BEATS     = 4,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int BEAT_W   = $clog2(BEATS),
   localparam int GROUP    = LANES / BEATS
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 fill_valid,
   input logic [WID_W-1:0]     fill_warp,
   input logic [NUM_WARPS-1:0] slot_busy,
   input logic                 issue_valid,
   input logic [WID_W-1:0]     issue_warp,
   input logic [INST_W-1:0]    issue_inst,
   input logic [BEAT_W-1:0]    issue_beat,
   input logic [LANES-1:0]     issue_lane_en,
   input logic                 sel_fire,
   input logic [WID_W-1:0]     sel_warp,
   input logic                 sel_dst_en,
   input logic [REG_W-1:0]     sel_dst,
   input logic [NUM_REGS-1:0]  pend [NUM_WARPS]
);
   logic             was_set;
   logic [WID_W-1:0] set_w;
   logic [REG_W-1:0] set_r;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         was_set <= 1'b0;
         set_w   <= '0;
         set_r   <= '0;
      end else begin
         was_set <= sel_fire && sel_dst_en;
         set_w   <= sel_warp;
         set_r   <= sel_dst;
      end
   end

   AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_beat != BEAT_W'(BEATS-1) |=>
      issue_valid && issue_beat == $past(issue_beat) + 1'b1); // R5
   AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_beat != BEAT_W'(BEATS-1) |=>
      $stable(issue_warp) && $stable(issue_inst)); // R5
   AST_START_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(issue_valid) |-> issue_beat == '0); // R5
   AST_LANE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> $countones(issue_lane_en) == GROUP); // R6
   AST_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> issue_lane_en == '0); // R6
   AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fire |=> !slot_busy[$past(sel_warp)]); // R10
   AST_FILL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && !slot_busy[fill_warp] |=> slot_busy[$past(fill_warp)]); // R2
   AST_PICK_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fire |-> slot_busy[sel_warp]); // R3
   AST_DST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      was_set |-> pend[set_w][set_r]); // R4
endmodule

bind warp_issue_sched wis_chk #(
   .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .INST_W(INST_W),
   .LANES(LANES), .BEATS(BEATS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_warp(fill_warp),
   .slot_busy(slot_busy), .issue_valid(issue_valid), .issue_warp(issue_warp),
   .issue_inst(issue_inst), .issue_beat(issue_beat), .issue_lane_en(issue_lane_en),
   .sel_fire(sel_fire), .sel_warp(sel_warp), .sel_dst_en(slot_de[sel_warp]),
   .sel_dst(slot_dst[sel_warp]), .pend(pend));

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
   localparam int NW = 4, NR = 8, IW = 16, AW = 2, LN = 32, BT = 4;
   localparam int GRP = LN / BT;
   localparam int AGE_SAT = (1 << AW) - 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          fill_valid, fill_dst_en, wb_valid;
   logic [1:0]    fill_warp, wb_warp;
   logic [IW-1:0] fill_inst;
   logic [2:0]    fill_src_a, fill_src_b, fill_dst, wb_reg;
   logic [NW-1:0] slot_busy;
   logic          issue_valid, issue_dst_en;
   logic [1:0]    issue_warp, issue_beat;
   logic [IW-1:0] issue_inst;
   logic [2:0]    issue_dst;
   logic [LN-1:0] issue_lane_en;

   warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .INST_W(IW), .AGE_W(AW),
                      .LANES(LN), .BEATS(BT)) u_warp_issue_sched (
      .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_warp(fill_warp),
      .fill_inst(fill_inst), .fill_src_a(fill_src_a), .fill_src_b(fill_src_b),
      .fill_dst(fill_dst), .fill_dst_en(fill_dst_en), .wb_valid(wb_valid),
      .wb_warp(wb_warp), .wb_reg(wb_reg), .slot_busy(slot_busy),
      .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_inst(issue_inst),
      .issue_dst(issue_dst), .issue_dst_en(issue_dst_en), .issue_beat(issue_beat),
      .issue_lane_en(issue_lane_en));

   int checks = 0, failures = 0, cycles = 0;
   bit done = 0;

   // reference state, built from the requirements
   bit      m_v [NW];
   int      m_inst [NW], m_sa [NW], m_sb [NW], m_dst [NW], m_age [NW];
   bit      m_de [NW];
   bit      m_pend [NW][NR];
   bit      m_iv, m_ide;
   int      m_beat, m_iw, m_iinst, m_idst;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         for (int w = 0; w < NW; w++) begin
            m_v[w] = 0; m_age[w] = 0;
            for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
         end
         m_iv = 0; m_beat = 0; m_iw = NW - 1;
      end else begin
         bit can, found;
         int win, best;
         can = !m_iv || m_beat == BT - 1;
         found = 0; win = 0; best = 0;
         for (int k = 0; k < NW; k++) begin
            int i;
            bit e;
            i = (m_iw + 1 + k) % NW;
            e = m_v[i] && !m_pend[i][m_sa[i]] && !m_pend[i][m_sb[i]]
                && !(m_de[i] && m_pend[i][m_dst[i]]);
            if (e && (!found || m_age[i] > best)) begin
               found = 1; best = m_age[i]; win = i;
            end
         end
         if (wb_valid) m_pend[wb_warp][wb_reg] = 0;
         if (can && found) begin
            if (m_de[win]) m_pend[win][m_dst[win]] = 1;
            m_iv = 1; m_beat = 0; m_iw = win; m_iinst = m_inst[win];
            m_idst = m_dst[win]; m_ide = m_de[win];
         end else if (m_iv) begin
            if (m_beat == BT - 1) m_iv = 0;
            else m_beat++;
         end
         for (int w = 0; w < NW; w++) begin
            if (can && found && win == w) m_v[w] = 0;
            else if (fill_valid && int'(fill_warp) == w && !m_v[w]) begin
               m_v[w] = 1; m_age[w] = 0; m_inst[w] = int'(fill_inst);
               m_sa[w] = int'(fill_src_a); m_sb[w] = int'(fill_src_b);
               m_dst[w] = int'(fill_dst); m_de[w] = fill_dst_en;
            end else if (m_v[w] && m_age[w] < AGE_SAT) m_age[w]++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic compare_all();
      logic [NW-1:0] exp_busy;
      logic [LN-1:0] exp_lane;
      for (int w = 0; w < NW; w++) exp_busy[w] = m_v[w];
      for (int l = 0; l < LN; l++) exp_lane[l] = m_iv && (l / GRP == m_beat);
      chk(slot_busy == exp_busy, "R2 R10 slot occupancy", int'(slot_busy), int'(exp_busy));
      chk(issue_valid == m_iv, "R5 issue_valid", int'(issue_valid), int'(m_iv));
      chk(issue_lane_en == exp_lane, "R6 lane enables", int'(issue_lane_en), int'(exp_lane));
      if (m_iv) begin
         chk(int'(issue_beat) == m_beat, "R5 beat", int'(issue_beat), m_beat);
         chk(int'(issue_warp) == m_iw, "R3 R7 R8 R9 chosen warp", int'(issue_warp), m_iw);
         chk(int'(issue_inst) == m_iinst, "R2 issued payload", int'(issue_inst), m_iinst);
         chk(int'(issue_dst) == m_idst && issue_dst_en == m_ide, "R4 issued destination",
             int'(issue_dst), m_idst);
      end
   endtask

   task automatic drv(input bit fv, input int fw, input int fi, input int sa, input int sb,
                      input int d, input bit de, input bit wv, input int ww, input int wr);
      fill_valid = fv; fill_warp = 2'(fw); fill_inst = IW'(fi);
      fill_src_a = 3'(sa); fill_src_b = 3'(sb); fill_dst = 3'(d); fill_dst_en = de;
      wb_valid = wv; wb_warp = 2'(ww); wb_reg = 3'(wr);
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
         cyc();
      end
   endtask

   initial begin
      rst_n = 1'b0;
      drv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: state straight out of reset
      chk(slot_busy == '0, "R1 slots empty", int'(slot_busy), 0);
      chk(!issue_valid, "R1 port idle", int'(issue_valid), 0);
      chk(issue_lane_en == '0, "R1 lanes off", int'(issue_lane_en), 0);

      // R4: producer on warp 0 writes r3
      drv(1, 0, 'h1111, 1, 2, 3, 1, 0, 0, 0); cyc();
      idle(2);
      // R3: consumer of r3 on warp 0 must wait
      drv(1, 0, 'h2222, 3, 0, 4, 1, 0, 0, 0); cyc();
      idle(8);
      chk(slot_busy[0], "R3 dependent instruction held", int'(slot_busy[0]), 1);
      // R9: independent warp 1 goes past the stalled warp
      drv(1, 1, 'h3333, 0, 0, 5, 1, 0, 0, 0); cyc();
      idle(1);
      chk(issue_valid && issue_warp == 2'd1, "R9 other warp issues", int'(issue_warp), 1);
      drv(0, 0, 0, 0, 0, 0, 0, 1, 0, 3); cyc();
      idle(8);
      chk(!slot_busy[0], "R3 released after writeback", int'(slot_busy[0]), 0);
      for (int w = 0; w < NW; w++) for (int r = 0; r < NR; r++)
         if (m_pend[w][r]) begin drv(0, 0, 0, 0, 0, 0, 0, 1, w, r); cyc(); end
      idle(4);

      // R7 R8: sweep with frequent saturated-age ties and writeback collisions
      for (int n = 0; n < 6000; n++) begin
         int ww, wr;
         bit fv, wv;
         fv = ($urandom % 3) != 0;
         wv = ($urandom % 2) == 0;
         ww = $urandom % NW;
         wr = $urandom % NR;
         for (int r = 0; r < NR; r++)
            if (m_pend[ww][(wr + r) % NR]) begin wr = (wr + r) % NR; break; end
         drv(fv, $urandom % NW, $urandom % 65536, $urandom % NR, $urandom % NR,
             $urandom % NR, ($urandom % 4) != 0, wv, ww, wr);
         cyc();
      end
      done = 1;
   end

   initial begin
      wait (done || cycles > 100000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule